// File: doc/BRIEF.md
# Standby Input Vector Controller

This block sits in front of a combinational logic cone. While the cone is active, the live input bus passes straight through to the cone. When a standby request arrives, the block drives a stored low-leakage vector onto the cone's inputs instead. This parks the cone's transistor stacks in a state that reduces subthreshold leakage. Power stays on throughout.

The standby vector is loaded serially through a scan path into a storage rank, and it can be read back at the scan output. A second rank captures the storage rank on the clock edge where standby begins. The cone's inputs are then fed from that second rank, so reloading the scan path during standby cannot disturb the applied vector. A status output tells a power manager that the stored vector is in place.

Top module: `ivc_sleep_ctrl`

## Requirements
- R1: Outside standby, `core_vec_o` equals `live_vec_i` in the same cycle, with no register in the path.
- R2: Standby is entered on a rising clock edge that samples `sleep_i` = 1 and `test_i` = 1. From that edge on, `core_vec_o` shows the applied rank and `vec_applied_o` is 1.
- R3: While `scan_en_i` is 1, each rising edge shifts `scan_in_i` into bit 0 of the storage rank and moves every bit one place toward the MSB. Shifting VEC_W bits MSB first therefore loads that vector.
- R4: `scan_out_o` always shows the MSB of the storage rank and holds its value while `scan_en_i` is 0.
- R5: On the standby-entry edge, the applied rank captures the storage rank as it was before that edge. The applied rank stays unchanged for the whole standby interval, even while the scan path shifts.
- R6: On the first rising edge that samples `sleep_i` and `test_i` not both 1, standby ends. From that edge on, `core_vec_o` follows `live_vec_i` again and `vec_applied_o` is 0.
- R7: A mixed control setting (`sleep_i` = 1 with `test_i` = 0, or the reverse) counts as operation, not standby.
- R8: An active-low `rst_ni` clears the storage rank, the applied rank and the mode at once. Release is synchronised over two clock edges. After reset, `scan_out_o` is 0 and entering standby without a load applies all zeros.
- R9: During standby, changes on `live_vec_i` do not reach `core_vec_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| live_vec_i | input | VEC_W | Live input vector for the cone |
| sleep_i | input | 1 | Standby request, paired with `test_i` |
| test_i | input | 1 | Second standby control |
| scan_in_i | input | 1 | Serial data into the storage rank |
| scan_en_i | input | 1 | Shift enable for the storage rank |
| scan_out_o | output | 1 | MSB of the storage rank |
| core_vec_o | output | VEC_W | Vector driven into the cone |
| vec_applied_o | output | 1 | Stored vector is being applied |

## Verification
The scan shift and the standby-entry capture can fall on the same clock edge. The bench provokes this by raising both controls while `scan_en_i` is high, then reloading the scan path during standby. It judges the result by checking that the cone sees the vector that was present before the entry edge, and that this vector does not move until standby ends. A fresh entry must then pick up the newly shifted vector.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_STBY = 1'b1
  } ivc_mode_e;
endpackage

// File: rtl/ivc_rst_sync.sv
module ivc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ivc_scan_store.sv
module ivc_scan_store #(
  parameter int VEC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             shift_in_i,
  output logic [VEC_W-1:0] store_o,
  output logic             shift_out_o
);
  logic [VEC_W-1:0] store_q;
  logic [VEC_W-1:0] store_d;

  always_comb begin
    store_d = store_q;
    if (shift_en_i) store_d = {store_q[VEC_W-2:0], shift_in_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) store_q <= '0;
    else         store_q <= store_d;
  end

  assign store_o     = store_q;
  assign shift_out_o = store_q[VEC_W-1];
endmodule

// File: rtl/ivc_hold_rank.sv
module ivc_hold_rank
  import ivc_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stby_req_i,
  input  logic [VEC_W-1:0] store_i,
  output logic [VEC_W-1:0] hold_o,
  output ivc_mode_e        mode_o
);
  ivc_mode_e        mode_q, mode_d;
  logic [VEC_W-1:0] hold_q, hold_d;
  logic             cap_en;

  always_comb begin
    cap_en = stby_req_i && (mode_q == MODE_RUN);
    mode_d = stby_req_i ? MODE_STBY : MODE_RUN;
    hold_d = cap_en ? store_i : hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      hold_q <= '0;
    end else begin
      mode_q <= mode_d;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/ivc_out_mux.sv
module ivc_out_mux #(
  parameter int VEC_W = 16
) (
  input  logic             sel_hold_i,
  input  logic [VEC_W-1:0] live_i,
  input  logic [VEC_W-1:0] hold_i,
  output logic [VEC_W-1:0] vec_o
);
  for (genvar b = 0; b < VEC_W; b++) begin : g_bit
    assign vec_o[b] = sel_hold_i ? hold_i[b] : live_i[b];
  end
endmodule

// File: rtl/ivc_sleep_ctrl.sv
module ivc_sleep_ctrl
  import ivc_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VEC_W-1:0] live_vec_i,
  input  logic             sleep_i,
  input  logic             test_i,
  input  logic             scan_in_i,
  input  logic             scan_en_i,
  output logic             scan_out_o,
  output logic [VEC_W-1:0] core_vec_o,
  output logic             vec_applied_o
);
  logic             rst_n_s;
  logic [VEC_W-1:0] store_vec;
  logic [VEC_W-1:0] hold_vec;
  ivc_mode_e        mode;
  logic             stby_req;

  assign stby_req = sleep_i & test_i;

  ivc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_s)
  );

  ivc_scan_store #(.VEC_W(VEC_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .shift_en_i (scan_en_i),
    .shift_in_i (scan_in_i),
    .store_o    (store_vec),
    .shift_out_o(scan_out_o)
  );

  ivc_hold_rank #(.VEC_W(VEC_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .stby_req_i(stby_req),
    .store_i   (store_vec),
    .hold_o    (hold_vec),
    .mode_o    (mode)
  );

  assign vec_applied_o = (mode == MODE_STBY);

  ivc_out_mux #(.VEC_W(VEC_W)) u_mux (
    .sel_hold_i(vec_applied_o),
    .live_i    (live_vec_i),
    .hold_i    (hold_vec),
    .vec_o     (core_vec_o)
  );
endmodule

// File: rtl/ivc_sleep_ctrl_chk.sv
module ivc_sleep_ctrl_chk #(
  parameter int VEC_W = 16
) (
  input logic             clk_i,
  input logic             rst_n_s,
  input logic             sleep_i,
  input logic             test_i,
  input logic             scan_en_i,
  input logic             scan_out_o,
  input logic [VEC_W-1:0] live_vec_i,
  input logic [VEC_W-1:0] core_vec_o,
  input logic             vec_applied_o
);
  a_r1_live_pass: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !vec_applied_o |-> core_vec_o == live_vec_i);

  a_r2_enter: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (sleep_i && test_i) |=> vec_applied_o);

  a_r6_r7_leave: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !(sleep_i && test_i) |=> !vec_applied_o);

  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (vec_applied_o && $past(vec_applied_o)) |-> $stable(core_vec_o));

  a_r4_scan_hold: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !scan_en_i |=> $stable(scan_out_o));
endmodule

bind ivc_sleep_ctrl ivc_sleep_ctrl_chk #(.VEC_W(VEC_W)) chk_i (
  .clk_i        (clk_i),
  .rst_n_s      (rst_n_s),
  .sleep_i      (sleep_i),
  .test_i       (test_i),
  .scan_en_i    (scan_en_i),
  .scan_out_o   (scan_out_o),
  .live_vec_i   (live_vec_i),
  .core_vec_o   (core_vec_o),
  .vec_applied_o(vec_applied_o)
);

// File: tb/ivc_sleep_ctrl_tb_top.sv
module ivc_sleep_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [W-1:0] VEC_A = 16'hA5C3;
  localparam logic [W-1:0] VEC_B = 16'h0F0F;

  typedef struct packed {
    logic         slp;
    logic         tst;
    logic [W-1:0] live;
    logic [W-1:0] exp_out;
    logic         exp_app;
  } row_t;

  localparam int NROWS = 6;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 1'b0, 16'h1234, 16'h1234, 1'b0},  // R1
    '{1'b1, 1'b0, 16'h5678, 16'h5678, 1'b0},  // R7
    '{1'b0, 1'b1, 16'h9ABC, 16'h9ABC, 1'b0},  // R7
    '{1'b1, 1'b1, 16'h1111, VEC_A,    1'b1},  // R2
    '{1'b1, 1'b1, 16'hFFFF, VEC_A,    1'b1},  // R9
    '{1'b0, 1'b0, 16'h4242, 16'h4242, 1'b0}   // R6
  };

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [W-1:0] live_vec_i;
  logic         sleep_i, test_i, scan_in_i, scan_en_i;
  logic         scan_out_o;
  logic [W-1:0] core_vec_o;
  logic         vec_applied_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ivc_sleep_ctrl #(.VEC_W(W)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .live_vec_i   (live_vec_i),
    .sleep_i      (sleep_i),
    .test_i       (test_i),
    .scan_in_i    (scan_in_i),
    .scan_en_i    (scan_en_i),
    .scan_out_o   (scan_out_o),
    .core_vec_o   (core_vec_o),
    .vec_applied_o(vec_applied_o)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, let the next posedge act, sample a quarter period later
  task automatic step();
    @(posedge clk_i);
    #(CLK_PERIOD/4);
  endtask

  task automatic load_vec(logic [W-1:0] v);
    for (int i = W-1; i >= 0; i--) begin
      @(negedge clk_i);
      scan_en_i = 1'b1;
      scan_in_i = v[i];
      step();
    end
    @(negedge clk_i);
    scan_en_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; live_vec_i = 16'h00FF; sleep_i = 1'b0; test_i = 1'b0;
    scan_in_i = 1'b0; scan_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R8 reset state
    chk("R8", W'(scan_out_o), '0);
    chk("R8", W'(vec_applied_o), '0);
    chk("R1", core_vec_o, 16'h00FF);

    // R3 load vector A, R4 MSB visible on scan output
    load_vec(VEC_A);
    chk("R4", W'(scan_out_o), W'(VEC_A[W-1]));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      scan_in_i = ~scan_in_i;
      step();
      chk("R4", W'(scan_out_o), W'(VEC_A[W-1]));
    end

    // table walk
    for (int r = 0; r < NROWS; r++) begin
      @(negedge clk_i);
      sleep_i = ROWS[r].slp; test_i = ROWS[r].tst; live_vec_i = ROWS[r].live;
      step();
      chk("R1/R2/R6/R7/R9 out", core_vec_o, ROWS[r].exp_out);
      chk("R2/R6/R7 applied", W'(vec_applied_o), W'(ROWS[r].exp_app));
    end

    // R5: entry on an edge where the scan path also shifts
    @(negedge clk_i);
    sleep_i = 1'b1; test_i = 1'b1; scan_en_i = 1'b1; scan_in_i = VEC_B[W-1];
    step();
    chk("R5 entry-with-shift", core_vec_o, VEC_A);
    for (int i = W-2; i >= 0; i--) begin
      @(negedge clk_i);
      scan_in_i = VEC_B[i];
      live_vec_i = live_vec_i + 16'h0101;
      step();
      if (i % 5 == 0) chk("R5 stable", core_vec_o, VEC_A);
    end
    @(negedge clk_i);
    scan_en_i = 1'b0;
    chk("R3 loaded during standby", W'(scan_out_o), W'(VEC_B[W-1]));
    sleep_i = 1'b0; test_i = 1'b0; live_vec_i = 16'h7777;
    step();
    chk("R6 exit", core_vec_o, 16'h7777);
    @(negedge clk_i);
    sleep_i = 1'b1; test_i = 1'b1;
    step();
    chk("R5 re-entry picks new vector", core_vec_o, VEC_B);
    @(negedge clk_i);
    sleep_i = 1'b0; test_i = 1'b0;
    step();

    // R3 readback of B through scan output
    begin
      logic [W-1:0] got;
      got = '0;
      for (int k = W-1; k >= 0; k--) begin
        @(negedge clk_i);
        got[k] = scan_out_o;
        scan_en_i = 1'b1; scan_in_i = 1'b0;
        step();
      end
      @(negedge clk_i);
      scan_en_i = 1'b0;
      chk("R3 readback", got, VEC_B);
    end

    // R8 reset in standby, then entry applies zeros
    load_vec(VEC_A);
    @(negedge clk_i);
    sleep_i = 1'b1; test_i = 1'b1; live_vec_i = 16'h3C3C;
    step();
    chk("R2 before reset", core_vec_o, VEC_A);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R8 async clear", core_vec_o, 16'h3C3C);
    chk("R8 async clear status", W'(vec_applied_o), '0);
    sleep_i = 1'b0; test_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R8 scan cleared", W'(scan_out_o), '0);
    sleep_i = 1'b1; test_i = 1'b1;
    step();
    chk("R8 zero vector", core_vec_o, '0);
    chk("R8 applied", W'(vec_applied_o), W'(1'b1));
    @(negedge clk_i);
    sleep_i = 1'b0; test_i = 1'b0;
    step();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule